// File: doc/BRIEF.md
# Byte-Stuffed Frame Decoder with CRC-8 Check

This block sits behind a UART receiver and turns its raw byte stream back into framed messages. A flag byte opens and closes each frame. An escape byte is dropped, and the byte after it is restored by flipping bit 5. The last restored byte before the closing flag is the frame's checksum and is not delivered as payload. Payload bytes leave the block one at a time with a last marker on the final one. In the same cycle as that final byte, a frame-done pulse reports whether the checksum matched.

Because the checksum byte can only be identified once the closing flag is seen, the decoder holds restored bytes back by two positions. One position holds the candidate checksum. The other holds the newest payload byte, which still waits for its last marker. Malformed frames are discarded with an error pulse: an escape directly followed by a flag, or more restored bytes than the configured limit. Frames with nothing to deliver are dropped silently.

Top module: `sframe_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is 0.
- R2: Bytes that arrive before the first flag byte (0x7E) since reset produce no output and no error pulse. This includes the escape byte 0x7D.
- R3: Inside a frame, an escape byte (0x7D) is removed, and the byte that follows it is delivered XORed with 0x20. This applies to any following byte other than 0x7E, including a second 0x7D.
- R4: The final restored byte before a closing flag is never delivered. The payload byte before it is delivered with out_last = 1 in the same cycle as frame_done. out_last and frame_done never occur apart.
- R5: At frame_done, crc_ok is 1 exactly when the withheld final byte equals the CRC-8 of the delivered payload bytes. The CRC uses polynomial x^8+x^5+x^4+1, processed LSB first (reflected constant 0x8C), with initial value 0xFF. crc_ok is 0 whenever frame_done is 0.
- R6: A closing flag that follows zero or one restored bytes produces no output, no frame_done and no error. Consecutive flags are an example of this.
- R7: A flag directly after an escape byte gives a one-cycle err_abort pulse with no frame_done, and bytes not yet delivered are discarded. That flag then opens a new frame, which decodes normally.
- R8: The restored byte that would exceed MAX_LEN (default 64) in one frame gives a one-cycle err_overflow pulse. Nothing more is delivered until the next flag, which produces no frame_done. The frame after that flag decodes normally.
- R9: A flag that closes one frame also opens the next, so frames may share a single flag between them.
- R10: Each delivered byte appears on the outputs one clock cycle after the input byte that releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_byte carries a received byte this cycle |
| in_byte | input | 8 | Received byte from the UART receiver |
| out_valid | output | 1 | out_byte carries a payload byte |
| out_byte | output | 8 | Restored payload byte |
| out_last | output | 1 | out_byte is the final payload byte of the frame |
| frame_done | output | 1 | One-cycle pulse: a frame closed with payload |
| crc_ok | output | 1 | Checksum matched (meaningful with frame_done) |
| err_abort | output | 1 | One-cycle pulse: frame aborted by escape+flag |
| err_overflow | output | 1 | One-cycle pulse: frame exceeded MAX_LEN bytes |

## Verification
The assertions assume that in_valid marks at most one byte per cycle and that reset is applied before traffic starts. They do not depend on any spacing between bytes. The bench drives each byte on a falling edge for exactly one cycle, sometimes back to back and sometimes with idle gaps, and it releases reset before the first byte. Escaped checksums, shared flags, aborts and a frame one byte over the limit are all produced by the bench's own encoder, so every input stays within these assumptions.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  localparam logic [7:0] FLAG_BYTE = 8'h7E;
  localparam logic [7:0] ESC_BYTE  = 8'h7D;
  localparam logic [7:0] ESC_MASK  = 8'h20;
  localparam logic [7:0] CRC_INIT  = 8'hFF;
  localparam logic [7:0] CRC_POLY_REFL = 8'h8C;

  // One byte of reflected CRC-8, LSB first.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] data);
    logic [7:0] c;
    logic [7:0] d;
    logic       fb;
    c = crc;
    d = data;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[0];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REFL;
      d  = d >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/sfd_unstuff.sv
module sfd_unstuff
  import sfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       dec_valid,
  output logic [7:0] dec_byte,
  output logic       flag_seen,
  output logic       abort_seen
);
  logic in_frame;
  logic esc;
  logic is_esc;

  assign flag_seen  = in_valid && (in_byte == FLAG_BYTE);
  assign abort_seen = flag_seen && esc;
  assign is_esc     = in_valid && in_frame && !esc && (in_byte == ESC_BYTE);
  assign dec_valid  = in_valid && in_frame && !flag_seen && !is_esc;
  assign dec_byte   = esc ? (in_byte ^ ESC_MASK) : in_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      esc      <= 1'b0;
    end else if (flag_seen) begin
      in_frame <= 1'b1;
      esc      <= 1'b0;
    end else if (is_esc) begin
      esc <= 1'b1;
    end else if (dec_valid) begin
      esc <= 1'b0;
    end
  end

  // R2: an escape can only be pending inside a frame
  assert_esc_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    esc |-> in_frame) else $error("escape pending outside a frame");

  // R3: a flag always clears a pending escape
  assert_flag_clears_esc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_seen |=> !esc) else $error("escape survived a flag");
endmodule

// File: rtl/sfd_crc_acc.sv
module sfd_crc_acc
  import sfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] data,
  output logic [7:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= CRC_INIT;
    else if (clr) crc <= CRC_INIT;
    else if (en)  crc <= crc8_step(crc, data);
  end

  // R5: a cleared accumulator starts from the initial value
  assert_crc_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == CRC_INIT)) else $error("crc not reinitialised");
endmodule

// File: rtl/sframe_decoder.sv
module sframe_decoder
  import sfd_pkg::*;
#(
  parameter int MAX_LEN = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       out_last,
  output logic       frame_done,
  output logic       crc_ok,
  output logic       err_abort,
  output logic       err_overflow
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  logic       dec_valid;
  logic [7:0] dec_byte;
  logic       flag_seen;
  logic       abort_seen;
  logic [7:0] crc_val;

  // holding stages: h1 = candidate checksum, h2 = newest pending payload
  logic       h1_vld, h2_vld;
  logic [7:0] h1_byte, h2_byte;
  logic [LEN_W-1:0] len;
  logic       dropping;

  // named internal events
  logic accept_ev;
  logic overflow_ev;
  logic close_ev;
  logic crc_clr;
  logic crc_en;

  sfd_unstuff u_unstuff (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .dec_valid(dec_valid), .dec_byte(dec_byte),
    .flag_seen(flag_seen), .abort_seen(abort_seen)
  );

  assign overflow_ev = dec_valid && !dropping && (len == LEN_W'(MAX_LEN));
  assign accept_ev   = dec_valid && !dropping && !overflow_ev;
  assign close_ev    = flag_seen && !abort_seen && !dropping && h2_vld && h1_vld;
  assign crc_clr     = flag_seen || overflow_ev;
  assign crc_en      = accept_ev && h1_vld;

  sfd_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
    .data(h1_byte), .crc(crc_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1_vld <= 1'b0; h2_vld <= 1'b0;
      h1_byte <= '0;  h2_byte <= '0;
      len <= '0; dropping <= 1'b0;
      out_valid <= 1'b0; out_byte <= '0; out_last <= 1'b0;
      frame_done <= 1'b0; crc_ok <= 1'b0;
      err_abort <= 1'b0; err_overflow <= 1'b0;
    end else begin
      out_valid    <= 1'b0;
      out_last     <= 1'b0;
      frame_done   <= 1'b0;
      crc_ok       <= 1'b0;
      err_abort    <= abort_seen;
      err_overflow <= overflow_ev;
      if (flag_seen) begin
        if (close_ev) begin
          out_valid  <= 1'b1;
          out_byte   <= h2_byte;
          out_last   <= 1'b1;
          frame_done <= 1'b1;
          crc_ok     <= (crc_val == h1_byte);
        end
        h1_vld <= 1'b0; h2_vld <= 1'b0;
        len <= '0; dropping <= 1'b0;
      end else if (overflow_ev) begin
        h1_vld <= 1'b0; h2_vld <= 1'b0;
        dropping <= 1'b1;
      end else if (accept_ev) begin
        len     <= len + 1'b1;
        h1_byte <= dec_byte;
        h1_vld  <= 1'b1;
        if (h1_vld) begin
          h2_byte <= h1_byte;
          h2_vld  <= 1'b1;
        end
        if (h2_vld) begin
          out_valid <= 1'b1;
          out_byte  <= h2_byte;
        end
      end
    end
  end

  // R4: last marker and frame completion travel together on a valid byte
  assert_last_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last || frame_done) |-> (out_valid && out_last && frame_done))
    else $error("last/done mismatch");

  // R5: crc_ok only qualifies a completed frame
  assert_crc_ok_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> frame_done) else $error("crc_ok without frame_done");

  // R7: an abort never completes a frame
  assert_abort_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_abort |-> !frame_done) else $error("abort with frame_done");

  // R8: nothing is delivered while discarding an oversized frame
  assert_no_output_dropping_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dropping && !flag_seen) |=> !out_valid) else $error("output while dropping");

  // R8: the length count never passes the limit
  assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    len <= LEN_W'(MAX_LEN)) else $error("length counter beyond limit");

  // R6: a pending payload byte always has a checksum candidate behind it
  assert_stage_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    h2_vld |-> h1_vld) else $error("payload stage without checksum stage");
endmodule

// File: tb/test_sframe_decoder.sv
`timescale 1ns/1ps
module test_sframe_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic       out_valid, out_last, frame_done, crc_ok, err_abort, err_overflow;
  logic [7:0] out_byte;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sframe_decoder #(.MAX_LEN(64)) i_sframe_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last),
    .frame_done(frame_done), .crc_ok(crc_ok),
    .err_abort(err_abort), .err_overflow(err_overflow)
  );

  // monitor
  logic [7:0] got [0:255];
  int n_got, n_last, last_idx, n_done, n_good, n_abort, n_ovf;

  task automatic clear_mon();
    n_got = 0; n_last = 0; last_idx = -1; n_done = 0; n_good = 0; n_abort = 0; n_ovf = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (n_got < 256) got[n_got] = out_byte;
        if (out_last) begin n_last++; last_idx = n_got; end
        n_got++;
      end
      if (frame_done) n_done++;
      if (frame_done && crc_ok) n_good++;
      if (err_abort) n_abort++;
      if (err_overflow) n_ovf++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  // reference checksum, table-free byte-xor form
  function automatic logic [7:0] ref_crc(input logic [7:0] pl [0:127], input int n);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ pl[i];
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 8'h8C) : (c >> 1);
    end
    return c;
  endfunction

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_stuffed(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin send(8'h7D); send(b ^ 8'h20); end
    else send(b);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // body plus checksum, no flags
  task automatic send_body(input logic [7:0] pl [0:127], input int n, input logic [7:0] crc_xor);
    for (int i = 0; i < n; i++) send_stuffed(pl[i]);
    send_stuffed(ref_crc(pl, n) ^ crc_xor);
  endtask

  task automatic check_payload(input string req, input logic [7:0] pl [0:127], input int n);
    chk(n_got == n, req, "payload count", n_got, n);
    for (int i = 0; i < n && i < n_got; i++)
      chk(got[i] == pl[i], req, $sformatf("payload byte %0d", i), got[i], pl[i]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(2);
    chk({out_valid, out_last, frame_done, crc_ok, err_abort, err_overflow} == 6'b0,
        "R1", "outputs in reset", {out_valid, frame_done, err_abort}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk({out_valid, out_last, frame_done, crc_ok, err_abort, err_overflow} == 6'b0,
        "R1", "outputs after reset", {out_valid, frame_done, err_abort}, 0);
  endtask

  task automatic t_outside_then_example();
    logic [7:0] ex [0:14] = '{8'h7e,8'h2f,8'h00,8'h05,8'h01,8'hff,8'hff,8'h00,
                              8'h7d,8'h5e,8'h7d,8'h5d,8'h7d,8'h5e,8'h7e};
    logic [7:0] pl [0:127];
    clear_mon();
    send(8'h11); send(8'h7D); send(8'h22); send(8'h33);
    idle(3);
    chk(n_got == 0 && n_abort == 0 && n_done == 0, "R2", "activity before first flag", n_got + n_abort, 0);
    pl[0]=8'h2f; pl[1]=8'h00; pl[2]=8'h05; pl[3]=8'h01; pl[4]=8'hff;
    pl[5]=8'hff; pl[6]=8'h00; pl[7]=8'h7e; pl[8]=8'h7d;
    for (int i = 0; i < 15; i++) send(ex[i]);
    idle(3);
    check_payload("R3", pl, 9);
    chk(n_last == 1 && last_idx == 8, "R4", "last marker index", last_idx, 8);
    chk(n_done == 1, "R4", "frame_done count", n_done, 1);
    chk(n_good == 1, "R5", "example crc_ok", n_good, 1);
    chk(ref_crc(pl, 9) == 8'h7E, "R5", "reference crc of example", ref_crc(pl, 9), 8'h7E);
  endtask

  task automatic t_escape_plain();
    logic [7:0] pl [0:127];
    clear_mon();
    send(8'h7E);
    send(8'h7D); send(8'h31);          // -> 0x11
    send(8'h7D); send(8'h7D);          // -> 0x5D
    send(8'h42);
    pl[0]=8'h11; pl[1]=8'h5D; pl[2]=8'h42;
    send_stuffed(ref_crc(pl, 3));
    send(8'h7E);
    idle(3);
    check_payload("R3", pl, 3);
    chk(n_good == 1 && n_done == 1, "R5", "escaped-plain frame crc_ok", n_good, 1);
  endtask

  task automatic t_bad_crc();
    logic [7:0] pl [0:127];
    clear_mon();
    pl[0]=8'hA1; pl[1]=8'h7E; pl[2]=8'h03;
    send(8'h7E); send_body(pl, 3, 8'h01); send(8'h7E);
    idle(3);
    check_payload("R5", pl, 3);
    chk(n_done == 1, "R5", "bad crc frame_done", n_done, 1);
    chk(n_good == 0, "R5", "bad crc crc_ok", n_good, 0);
    chk(n_abort == 0 && n_ovf == 0, "R5", "bad crc errors", n_abort + n_ovf, 0);
  endtask

  task automatic t_empty();
    clear_mon();
    send(8'h7E); send(8'h7E); send(8'h7E);
    send(8'h55); send(8'h7E);
    send(8'h7D); send(8'h5E); send(8'h7E);
    idle(3);
    chk(n_got == 0, "R6", "empty frame output", n_got, 0);
    chk(n_done == 0, "R6", "empty frame done", n_done, 0);
    chk(n_abort == 0 && n_ovf == 0, "R6", "empty frame errors", n_abort + n_ovf, 0);
  endtask

  task automatic t_abort();
    logic [7:0] pl [0:127];
    clear_mon();
    send(8'h7E); send(8'h10); send(8'h20); send(8'h30);
    send(8'h7D); send(8'h7E);            // abort, flag opens next frame
    pl[0]=8'h41; pl[1]=8'h42;
    send_body(pl, 2, 8'h00); send(8'h7E);
    idle(3);
    chk(n_abort == 1, "R7", "abort pulses", n_abort, 1);
    chk(got[0] == 8'h10 && n_got == 3, "R7", "bytes before abort then new frame count", n_got, 3);
    chk(n_got == 3 && got[1] == 8'h41 && got[2] == 8'h42, "R7", "new frame payload", got[1], 8'h41);
    chk(n_done == 1 && n_good == 1, "R7", "new frame completes good", n_good, 1);
  endtask

  task automatic t_shared_flag();
    logic [7:0] pa [0:127];
    logic [7:0] pb [0:127];
    clear_mon();
    pa[0]=8'h01; pa[1]=8'h02;
    pb[0]=8'h7D; pb[1]=8'h03; pb[2]=8'h04;
    send(8'h7E); send_body(pa, 2, 8'h00);
    send(8'h7E); send_body(pb, 3, 8'h00); send(8'h7E);
    idle(3);
    chk(n_done == 2 && n_good == 2, "R9", "two frames on shared flag", n_good, 2);
    chk(n_got == 5 && n_last == 2, "R9", "shared flag byte count", n_got, 5);
    chk(n_got == 5 && got[2] == 8'h7D && got[4] == 8'h04, "R9", "second frame bytes", got[2], 8'h7D);
  endtask

  task automatic t_latency();
    int cyc;
    clear_mon();
    send(8'h7E); send(8'h61); send(8'h62);
    in_valid = 1'b1; in_byte = 8'h63;    // releases 0x61
    @(posedge clk); #1 in_valid = 1'b0;
    cyc = out_valid;
    chk(cyc == 1 && out_byte == 8'h61, "R10", "release one cycle after input", out_byte, 8'h61);
    @(negedge clk);
    send(8'h7E);
    idle(3);
  endtask

  task automatic t_overflow();
    logic [7:0] pl [0:127];
    clear_mon();
    send(8'h7E);
    for (int i = 0; i < 65; i++) send(8'h01 + 8'(i));
    send(8'h22);
    idle(2);
    chk(n_ovf == 1, "R8", "overflow pulse", n_ovf, 1);
    chk(n_got == 62, "R8", "bytes delivered before overflow", n_got, 62);
    send(8'h7E);
    idle(3);
    chk(n_done == 0 && n_last == 0, "R8", "no done after overflow", n_done, 0);
    clear_mon();
    pl[0]=8'h99; pl[1]=8'h98;
    send_body(pl, 2, 8'h00); send(8'h7E);
    idle(3);
    chk(n_done == 1 && n_good == 1 && n_got == 2, "R8", "recovery frame", n_got, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    clear_mon();
    @(negedge clk);
    t_reset();
    t_outside_then_example();
    t_escape_plain();
    t_bad_crc();
    t_empty();
    t_abort();
    t_shared_flag();
    t_latency();
    t_overflow();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule